// File: doc/BRIEF.md
# Clock Rate Measurement Counter

This block counts cycles of a clock under measurement so that software can work out that clock's frequency. Software reads the count twice, a known time apart, and divides the difference by the elapsed time. The counter runs in the measured clock's own domain. A configuration register and the readback registers live in the register clock domain. Control settings cross into the counting domain through two-flop synchronizers. The count crosses back as whole snapshots over a toggle handshake, so every value that software sees is a single coherent sample.

The configuration word holds the following fields. Bit 0 is the counter reset: 1 clears the counter and holds it clear. Bit 1 is the count enable. Bit 2 enables the periodic refresh of the readable count. Bits [7:4] select the source, and the block drives them out on `src_sel` to an external clock multiplexer. Bits [15:8] set the refresh spacing in counted-clock cycles. The count is wider than one data word. The low part is read at one address and the upper bits at another. Reading the low part freezes the matching upper bits, so the two halves always belong to the same sample.

After reset is released, the counter stays at zero for a fixed number of counted-clock cycles. A single write cannot release the reset and also start counting: a count enable carried by the same write that releases reset is dropped.

Top module: `clk_rate_counter`

## Requirements
- R1: Address 0 reads back the configuration word laid out as stated above, with reset value 0x0F05 (reset asserted, refresh enabled, spacing 15). The source field appears on `src_sel`.
- R2: While counting, the count rises by exactly one per counted-clock cycle. The difference between two readings equals elapsed time divided by the counted period, within the refresh granularity.
- R3: Address 1 returns the low LO_W count bits, zero-extended. Address 2 returns the upper CNT_W-LO_W bits in its least significant positions, with all other bits zero.
- R4: A read of address 1 captures the upper count bits into a shadow. A later read of address 2 returns that shadow, even if the count has moved on since.
- R5: While the reset bit is 1, the count is zero. After the bit is cleared, the count stays zero for RST_CYC (16) further counted-clock cycles before counting begins.
- R6: A write that changes the reset bit from 1 to 0 stores the count enable as 0, whatever the written value. Counting then needs a second write.
- R7: With the count enable at 0, the count holds its last value.
- R8: With refresh disabled, the readable count stays frozen. With refresh enabled, a new snapshot is taken every spacing+1 counted cycles, or as soon as the handshake is free after that.
- R9: The count wraps modulo 2^CNT_W.
- R10: Read data is registered and appears the cycle after `rd_en`. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-side clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| cnt_clk | input | 1 | Clock being measured |
| cnt_rst | input | 1 | Synchronous active-high reset, counted domain |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| src_sel | output | SRC_W | Source select to the clock multiplexer |

## Verification
A bad counter step or a broken wrap appears as a count difference that departs from elapsed time divided by the clock period. The error is visible within one interval of a few hundred register cycles, tested at several clock periods. A shadow that follows the live count instead of the sample appears as a paired reading off by whole multiples of the low-part range, using a narrow second instance whose upper bits change quickly. A reset stretch that is missing or too short, or a count enable that slips through on the release write, shows up as a count too high by about sixteen, read a few hundred cycles after the enabling write.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;
  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_LO   = 2'd1,
    A_HI   = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  localparam int F_RST   = 0;
  localparam int F_START = 1;
  localparam int F_CONT  = 2;
  localparam int F_SRC   = 4;
  localparam int F_UPD   = 8;
endpackage

// File: rtl/rate_sync.sv
module rate_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rate_cnt_core.sv
module rate_cnt_core #(
  parameter int CNT_W = 36,
  parameter int UPD_W = 8,
  parameter int RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_req,
  input  logic             start_req,
  input  logic             cont_req,
  input  logic [UPD_W-1:0] upd_period,
  input  logic             snap_ready,
  output logic [CNT_W-1:0] count,
  output logic             rst_busy,
  output logic             snap_take
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  logic [RC_W-1:0]  rst_left;
  logic [UPD_W-1:0] upd_tmr;
  logic             upd_due;

  assign upd_due  = (upd_tmr >= upd_period);
  assign rst_busy = rst_req || (rst_left != '0);

  always_comb snap_take = cont_req && upd_due && snap_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      rst_left <= RC_W'(RST_CYC);
      upd_tmr  <= '0;
    end else begin
      if (rst_req) begin
        rst_left <= RC_W'(RST_CYC);
        count    <= '0;
      end else if (rst_left != '0) begin
        rst_left <= rst_left - 1'b1;
        count    <= '0;
      end else if (start_req) begin
        count <= count + 1'b1;
      end

      if (!cont_req || snap_take) upd_tmr <= '0;
      else if (!upd_due)          upd_tmr <= upd_tmr + 1'b1;
    end
  end
endmodule

// File: rtl/rate_snap_xfer.sv
module rate_snap_xfer #(
  parameter int W = 36,
  parameter int STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic         ready,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic [W-1:0] dout
);
  logic         req_tgl;
  logic         ack_tgl;
  logic         ack_s;
  logic         req_s;
  logic [W-1:0] snap_q;

  rate_sync #(.W(1), .STAGES(STAGES)) u_ack (
    .clk(src_clk), .rst(src_rst), .d(ack_tgl), .q(ack_s)
  );

  assign ready = (req_tgl == ack_s);

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      req_tgl <= 1'b0;
      snap_q  <= '0;
    end else if (take && ready) begin
      snap_q  <= din;
      req_tgl <= ~req_tgl;
    end
  end

  rate_sync #(.W(1), .STAGES(STAGES)) u_req (
    .clk(dst_clk), .rst(dst_rst), .d(req_tgl), .q(req_s)
  );

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      ack_tgl <= 1'b0;
      dout    <= '0;
    end else if (req_s != ack_tgl) begin
      dout    <= snap_q;
      ack_tgl <= req_s;
    end
  end
endmodule

// File: rtl/rate_cfg_regs.sv
module rate_cfg_regs
  import clk_rate_pkg::*;
#(
  parameter int DW = 32,
  parameter int CNT_W = 36,
  parameter int LO_W = 32,
  parameter int SRC_W = 4,
  parameter int UPD_W = 8,
  parameter int UPD_RST = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [DW-1:0]    rdata,
  output logic             cfg_rst,
  output logic             cfg_start,
  output logic             cfg_cont,
  output logic [SRC_W-1:0] cfg_src,
  output logic [UPD_W-1:0] cfg_upd
);
  localparam int HI_W = CNT_W - LO_W;

  logic [HI_W-1:0] hi_shadow;
  logic [DW-1:0]   cfg_word;
  logic [DW-1:0]   lo_word;
  logic [DW-1:0]   hi_word;
  logic            unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    cfg_word                  = '0;
    cfg_word[F_RST]           = cfg_rst;
    cfg_word[F_START]         = cfg_start;
    cfg_word[F_CONT]          = cfg_cont;
    cfg_word[F_SRC +: SRC_W]  = cfg_src;
    cfg_word[F_UPD +: UPD_W]  = cfg_upd;
    lo_word                   = '0;
    lo_word[LO_W-1:0]         = cnt_val[LO_W-1:0];
    hi_word                   = '0;
    hi_word[HI_W-1:0]         = hi_shadow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rst   <= 1'b1;
      cfg_start <= 1'b0;
      cfg_cont  <= 1'b1;
      cfg_src   <= '0;
      cfg_upd   <= UPD_W'(UPD_RST);
    end else if (wr_en && (reg_addr_e'(addr) == A_CFG)) begin
      cfg_rst   <= wdata[F_RST];
      // releasing reset and enabling the count need separate writes
      cfg_start <= wdata[F_START] && !(cfg_rst && !wdata[F_RST]);
      cfg_cont  <= wdata[F_CONT];
      cfg_src   <= wdata[F_SRC +: SRC_W];
      cfg_upd   <= wdata[F_UPD +: UPD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      hi_shadow <= '0;
    end else if (rd_en) begin
      case (reg_addr_e'(addr))
        A_CFG: rdata <= cfg_word;
        A_LO: begin
          rdata     <= lo_word;
          hi_shadow <= cnt_val[CNT_W-1:LO_W];
        end
        A_HI:    rdata <= hi_word;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/clk_rate_counter.sv
module clk_rate_counter #(
  parameter int DW = 32,
  parameter int CNT_W = 36,
  parameter int LO_W = 32,
  parameter int SRC_W = 4,
  parameter int UPD_W = 8,
  parameter int UPD_RST = 15,
  parameter int RST_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             reg_clk,
  input  logic             reg_rst,
  input  logic             cnt_clk,
  input  logic             cnt_rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [SRC_W-1:0] src_sel
);
  localparam int CTL_W = 3 + UPD_W;
  localparam logic [CTL_W-1:0] CTL_RST = {1'b1, 1'b0, 1'b1, UPD_W'(UPD_RST)};

  logic             cfg_rst;
  logic             cfg_start;
  logic             cfg_cont;
  logic [UPD_W-1:0] cfg_upd;
  logic [CNT_W-1:0] cnt_reg;
  logic [CTL_W-1:0] ctl_s;
  logic             rst_req_s;
  logic             start_s;
  logic             cont_s;
  logic [UPD_W-1:0] upd_s;
  logic [CNT_W-1:0] cnt_val;
  logic             rst_busy;
  logic             snap_take;
  logic             xfer_ready;

  rate_cfg_regs #(
    .DW(DW), .CNT_W(CNT_W), .LO_W(LO_W), .SRC_W(SRC_W),
    .UPD_W(UPD_W), .UPD_RST(UPD_RST)
  ) u_regs (
    .clk(reg_clk), .rst(reg_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .cnt_val(cnt_reg), .rdata(rdata),
    .cfg_rst(cfg_rst), .cfg_start(cfg_start), .cfg_cont(cfg_cont),
    .cfg_src(src_sel), .cfg_upd(cfg_upd)
  );

  rate_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(cnt_clk), .rst(cnt_rst),
    .d({cfg_rst, cfg_start, cfg_cont, cfg_upd}), .q(ctl_s)
  );

  assign {rst_req_s, start_s, cont_s, upd_s} = ctl_s;

  rate_cnt_core #(.CNT_W(CNT_W), .UPD_W(UPD_W), .RST_CYC(RST_CYC)) u_core (
    .clk(cnt_clk), .rst(cnt_rst), .rst_req(rst_req_s), .start_req(start_s),
    .cont_req(cont_s), .upd_period(upd_s), .snap_ready(xfer_ready),
    .count(cnt_val), .rst_busy(rst_busy), .snap_take(snap_take)
  );

  rate_snap_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_xfer (
    .src_clk(cnt_clk), .src_rst(cnt_rst), .take(snap_take), .din(cnt_val),
    .ready(xfer_ready), .dst_clk(reg_clk), .dst_rst(reg_rst), .dout(cnt_reg)
  );
endmodule

// File: rtl/clk_rate_counter_chk.sv
module clk_rate_counter_chk #(
  parameter int DW = 32,
  parameter int CNT_W = 36,
  parameter int LO_W = 32,
  parameter int RST_CYC = 16
) (
  input logic             reg_clk,
  input logic             reg_rst,
  input logic             cnt_clk,
  input logic             cnt_rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic             cfg_rst,
  input logic             cfg_start,
  input logic [CNT_W-1:0] cnt_val,
  input logic             rst_req_s,
  input logic             start_s,
  input logic             rst_busy
);
  localparam int HI_W = CNT_W - LO_W;
  localparam int SW = $clog2(RST_CYC + 1);

  logic [SW-1:0] since_rel;

  always_ff @(posedge cnt_clk) begin
    if (cnt_rst || rst_req_s) since_rel <= '0;
    else if (since_rel < SW'(RST_CYC)) since_rel <= since_rel + 1'b1;
  end

  a_r3_hi_pad_zero: assert property (@(posedge reg_clk) disable iff (reg_rst)
    (rd_en && addr == 2'd2) |=> ((rdata >> HI_W) == '0));

  a_r10_unmapped_zero: assert property (@(posedge reg_clk) disable iff (reg_rst)
    (rd_en && addr == 2'd3) |=> (rdata == '0));

  a_r6_split_release: assert property (@(posedge reg_clk) disable iff (reg_rst)
    (wr_en && addr == 2'd0 && cfg_rst && !wdata[0]) |=> !cfg_start);

  a_r5_hold_zero: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    rst_req_s |=> (cnt_val == '0));

  a_r5_stretch: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    (since_rel < SW'(RST_CYC)) |-> (cnt_val == '0));

  a_r7_hold_count: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    (!start_s && !rst_req_s) |=> $stable(cnt_val));

  a_r2_step_one: assert property (@(posedge cnt_clk) disable iff (cnt_rst)
    (start_s && !rst_busy) |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));
endmodule

bind clk_rate_counter clk_rate_counter_chk #(
  .DW(DW), .CNT_W(CNT_W), .LO_W(LO_W), .RST_CYC(RST_CYC)
) u_chk (
  .reg_clk(reg_clk), .reg_rst(reg_rst), .cnt_clk(cnt_clk), .cnt_rst(cnt_rst),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .cfg_rst(cfg_rst), .cfg_start(cfg_start), .cnt_val(cnt_val),
  .rst_req_s(rst_req_s), .start_s(start_s), .rst_busy(rst_busy)
);

// File: tb/sim_clk_rate_counter.sv
`timescale 1ns/1ps
module sim_clk_rate_counter;
  logic reg_clk = 1'b0;
  logic cnt_clk = 1'b0;
  logic reg_rst = 1'b1;
  logic cnt_rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [3:0] src0, src1;
  real cnt_half = 4.0;
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] last_h0, last_h1, last_l1;

  always #10 reg_clk = ~reg_clk;
  initial forever begin #(cnt_half) cnt_clk = ~cnt_clk; end

  clk_rate_counter u0 (
    .reg_clk(reg_clk), .reg_rst(reg_rst), .cnt_clk(cnt_clk), .cnt_rst(cnt_rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .src_sel(src0)
  );

  clk_rate_counter #(.CNT_W(12), .LO_W(8)) u1 (
    .reg_clk(reg_clk), .reg_rst(reg_rst), .cnt_clk(cnt_clk), .cnt_rst(cnt_rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata1), .src_sel(src1)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, output real t);
    @(negedge reg_clk);
    wr_en = 1'b1; addr = 2'd0; wdata = d; t = $realtime + 10.0;
    @(negedge reg_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v0, output logic [31:0] v1,
                    output real t);
    @(negedge reg_clk);
    rd_en = 1'b1; addr = a; t = $realtime + 10.0;
    @(negedge reg_clk);
    rd_en = 1'b0;
    v0 = rdata0; v1 = rdata1;
  endtask

  task automatic rd_cnt(input int hi_gap, output longint c0, output longint c1, output real t);
    logic [31:0] l0, l1, h0, h1;
    real tx;
    rd(2'd1, l0, l1, t);
    repeat (hi_gap) @(negedge reg_clk);
    rd(2'd2, h0, h1, tx);
    c0 = (longint'(h0[3:0]) << 32) | longint'(l0);
    c1 = longint'({h1[3:0], l1[7:0]});
    last_h0 = h0; last_h1 = h1; last_l1 = l1;
  endtask

  function automatic bit circ_ok(input longint meas, input real e, input real tol);
    longint dd;
    dd = (meas - longint'(e)) % 4096;
    if (dd < 0) dd += 4096;
    if (dd > 2048) dd -= 4096;
    return (real'(dd) <= tol) && (real'(dd) >= -tol);
  endfunction

  function automatic real tol_for(input real per, input int upd);
    return real'(upd) + 1.0 + 60.0 / per + 8.0;
  endfunction

  initial begin
    repeat (150000) @(posedge reg_clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v0, v1;
    longint a0, a1, b0, b1, c0, c1;
    real ta, tb, tx, e, tol, per;
    real per_tab [4] = '{8.0, 12.0, 30.0, 37.0};
    int r;
    void'($urandom(32'd1234));

    repeat (5) @(negedge reg_clk);
    reg_rst = 1'b0; cnt_rst = 1'b0;
    repeat (5) @(negedge reg_clk);

    // reset state
    rd(2'd0, v0, v1, tx);
    chk(v0 == 32'h0F05, "R1 cfg reset value u0", v0, 32'h0F05);
    chk(v1 == 32'h0F05, "R1 cfg reset value u1", v1, 32'h0F05);
    rd_cnt(0, a0, a1, ta);
    chk(a0 == 0 && a1 == 0, "R5 count zero in reset", a0 + a1, 0);
    rd(2'd3, v0, v1, tx);
    chk(v0 == 0 && v1 == 0, "R10 unmapped address", v0 | v1, 0);

    // release and start in one write: start dropped
    wr(32'h0F06, tx);
    rd(2'd0, v0, v1, tx);
    chk(v0 == 32'h0F04, "R6 start dropped on release write", v0, 32'h0F04);
    repeat (100) @(negedge reg_clk);
    rd_cnt(0, a0, a1, ta);
    chk(a0 == 0, "R6 count still idle", a0, 0);

    wr(32'h0F56, tx);
    rd(2'd0, v0, v1, tx);
    chk(v0 == 32'h0F56, "R1 cfg readback", v0, 32'h0F56);
    chk(src0 == 4'd5, "R1 source select port", src0, 5);

    // rate checks at several counted periods
    r = $urandom % 4;
    for (int i = 0; i < 4; i++) begin
      int n, gap;
      per = per_tab[(i + r) % 4];
      cnt_half = per / 2.0;
      repeat (50) @(negedge reg_clk);
      rd_cnt(0, a0, a1, ta);
      n = 300 + ($urandom % 1200);
      repeat (n) @(negedge reg_clk);
      gap = int'(300.0 * per / 20.0) + ($urandom % 50);
      rd_cnt(gap, b0, b1, tb);
      e = (tb - ta) / per;
      tol = tol_for(per, 15);
      chk((real'(b0 - a0) <= e + tol) && (real'(b0 - a0) >= e - tol),
          "R2 rate delta u0", b0 - a0, longint'(e));
      chk(last_h0 == 0, "R3 high word u0", last_h0, 0);
      chk(last_h1[31:4] == 0 && last_l1[31:8] == 0, "R3 field padding u1",
          {last_h1[31:4], last_l1[31:8]}, 0);
      chk(circ_ok(b1 - a1, e, tol), "R4 R9 shadowed wrap delta u1",
          (b1 - a1) & 4095, longint'(e) % 4096);
    end

    // count enable off: hold
    cnt_half = 4.0;
    wr(32'h0F54, tx);
    repeat (100) @(negedge reg_clk);
    rd_cnt(0, a0, a1, ta);
    repeat (300) @(negedge reg_clk);
    rd_cnt(0, b0, b1, tb);
    chk(a0 == b0 && a0 != 0, "R7 count holds", b0, a0);

    // refresh off: frozen readback
    wr(32'h0F56, tx);
    repeat (100) @(negedge reg_clk);
    wr(32'h0F52, tx);
    repeat (50) @(negedge reg_clk);
    rd_cnt(0, a0, a1, ta);
    repeat (400) @(negedge reg_clk);
    rd_cnt(0, b0, b1, tb);
    chk(a0 == b0, "R8 frozen without refresh", b0, a0);
    wr(32'h0F56, tx);
    repeat (100) @(negedge reg_clk);
    rd_cnt(0, c0, c1, tx);
    chk(c0 > b0 + 400, "R8 refresh resumes", c0, b0 + 400);

    // reset stretch after release
    cnt_half = 18.5;
    wr(32'h0057, tx);
    repeat (60) @(negedge reg_clk);
    rd_cnt(0, a0, a1, ta);
    chk(a0 == 0 && a1 == 0, "R5 cleared while reset set", a0 + a1, 0);
    wr(32'h0056, tx);
    wr(32'h0056, ta);
    repeat (200) @(negedge reg_clk);
    rd_cnt(0, b0, b1, tb);
    e = (tb - ta) / 37.0;
    chk(real'(b0) <= e - 12.0 && real'(b0) >= e - 30.0, "R5 zero hold after release u0",
        b0, longint'(e) - 16);
    chk(real'(b1) <= e - 12.0 && real'(b1) >= e - 30.0, "R5 zero hold after release u1",
        b1, longint'(e) - 16);
    rd(2'd0, v0, v1, tx);
    chk(v0 == 32'h0056, "R1 cfg after second write", v0, 32'h0056);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule